// File: doc/BRIEF.md
# Dual Programmable PWM Clock Divider

This block derives two independent divided clock enables, called A and B, from the master clock. The PWM channels of a larger timer use them as their count strobes. Each divided clock is a cascade of two stages. The first is a power-of-two prescaler. The second is an 8-bit linear divisor that counts the prescaler's strobes. On each output, the block emits a pulse one master clock wide once per divided period. It never gates a clock.

Both dividers take their settings from one 32-bit mode register. A write port loads the register, and a read-back port always shows its contents. A half-word of all zeros turns its clock off. The divider never doubles its own period. A channel that uses centre-aligned output sees a doubled period because of how that channel counts, not because of this block.

Any write that changes a half-word restarts that clock's counters. The first tick after such a write therefore arrives exactly one full new period later. A write that leaves a half-word unchanged has no effect on that clock's phase.

Top module: `pwmdiv_top`

## Requirements
- R1: After reset, the mode register reads zero, and neither tick output pulses.
- R2: When `wr_en` is high at a clock edge, the register stores all 32 bits of `wr_data`, and `mode_q` shows them from the next cycle. Without `wr_en`, `mode_q` does not change.
- R3: Clock A uses bits [15:0] and clock B uses bits [31:16]. In each half, bits [7:0] hold the divisor d and bits [11:8] hold the prescale exponent p. A running clock ticks once every 2^p × d master cycles. Bits [15:12] of each half do not affect timing.
- R4: Each tick is one master cycle wide. With p=0 and d=1, the output is high on every cycle.
- R5: A half-word equal to zero produces no ticks.
- R6: A half-word with p greater than 10, or with d equal to 0, is treated as off and produces no ticks.
- R7: A write that changes any bit of a half-word restarts that clock. Its first tick shows on the output in the cycle that follows the P-th clock edge after the write edge, where P is the new period.
- R8: A write that leaves a half-word unchanged does not disturb that clock's tick phase.
- R9: A change to one half-word does not disturb the tick phase of the other clock.
- R10: The largest prescale exponent, p=10, gives a period of 1024 × d cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Loads the mode register from `wr_data` |
| wr_data | input | 32 | New mode register value |
| mode_q | output | 32 | Read-back of the mode register |
| tick_a | output | 1 | One-cycle enable, once per period of clock A |
| tick_b | output | 1 | One-cycle enable, once per period of clock B |

## Verification
The hardest cases to reach from the ports are writes that land in the middle of a period. These include a changed half-word arriving mid-count, an identical rewrite arriving mid-count, and a change to only the other half. Each must either restart the phase or leave it untouched. The stimulus writes at random cycles with short periods, and often repeats the current half-word or changes only one side. The bench model tracks, for each half, the edges counted since its last restart. It then predicts every tick from that count alone. Directed runs add the one-cycle period, the 1024-cycle prescale and the two kinds of invalid setting.

// File: rtl/pwmdiv_pkg.sv
// pwmdiv_pkg: shared constants and the half-word layout of the divider
// mode register. Assumes two clocks packed into one 32-bit register.
package pwmdiv_pkg;
    localparam int NUM_CLK = 2;
    localparam int HALF_W  = 16;
    localparam int DIV_W   = 8;
    localparam int PSC_W   = 4;
    localparam int PSC_MAX = 10;
    localparam int MODE_W  = NUM_CLK * HALF_W;

    // One clock's settings; the top bits are stored but do not affect timing.
    typedef struct packed {
        logic [HALF_W-DIV_W-PSC_W-1:0] spare;
        logic [PSC_W-1:0]              psc;
        logic [DIV_W-1:0]              div;
    } half_cfg_t;
endpackage

// File: rtl/pwmdiv_mode_reg.sv
// pwmdiv_mode_reg: holds the mode register and flags, per half-word,
// a write that changes that half. Assumes a synchronous active-low reset
// and that the register clears to zero (both clocks off).
module pwmdiv_mode_reg
    import pwmdiv_pkg::*;
#(
    parameter int N_HALF = NUM_CLK,
    parameter int H_W    = HALF_W,
    localparam int W     = N_HALF * H_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     mode_q,
    output logic [N_HALF-1:0] restart_o
);

    // Per-half change detection against the value currently held.
    for (genvar g = 0; g < N_HALF; g++) begin : g_chg
        assign restart_o[g] = wr_en &&
            (wr_data[g*H_W +: H_W] != mode_q[g*H_W +: H_W]);
    end

    // Register load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= '0;
        else if (wr_en) mode_q <= wr_data;
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q == $past(wr_data)));

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/pwmdiv_divider.sv
// pwmdiv_divider: one divided clock enable. A 2^psc prescaler feeds a
// linear counter of div strobes; a one-cycle tick closes each period.
// Assumes the settings only change together with restart_i.
module pwmdiv_divider #(
    parameter int DIV_W   = 8,
    parameter int PSC_W   = 4,
    parameter int PSC_MAX = 10,
    localparam int PCNT_W = (PSC_MAX > 0) ? PSC_MAX : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             restart_i,
    output logic             tick_o
);

    logic              run;
    logic [PCNT_W:0]   one_sh;
    logic [PCNT_W-1:0] pmask;
    logic [PCNT_W-1:0] pcnt;
    logic [DIV_W-1:0]  dcnt;
    logic              pend;
    logic              dend;

    // Valid settings: nonzero divisor and an exponent within range.
    assign run = (div_i != '0) && (int'(psc_i) <= PSC_MAX);

    // Terminal count of the prescaler, 2^psc - 1 (wraps to all ones at max).
    assign one_sh = (PCNT_W+1)'(1) << psc_i;
    assign pmask  = one_sh[PCNT_W-1:0] - PCNT_W'(1);

    // End-of-stage flags for the prescaler and the linear counter.
    assign pend = (pcnt == pmask);
    assign dend = (dcnt == div_i - DIV_W'(1));

    // Cascade counters and the registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !run) begin
            pcnt   <= '0;
            dcnt   <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= pend && dend;
            if (pend) begin
                pcnt <= '0;
                dcnt <= dend ? '0 : dcnt + DIV_W'(1);
            end else begin
                pcnt <= pcnt + PCNT_W'(1);
            end
        end
    end

    assert_zero_div_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |=> !tick_o);

    assert_big_psc_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(psc_i) > PSC_MAX) |=> !tick_o);

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pcnt == '0 && dcnt == '0 && !tick_o));

    assert_tick_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (pcnt == '0 && dcnt == '0));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (psc_i != '0 || div_i != DIV_W'(1))) |=> !tick_o);

    assert_dcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (dcnt < div_i));

endmodule

// File: rtl/pwmdiv_top.sv
// pwmdiv_top: two programmable clock-enable dividers configured by one
// 32-bit mode register (A in the low half, B in the high half).
// Assumes a single master clock and a synchronous active-low reset.
module pwmdiv_top
    import pwmdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output logic [MODE_W-1:0] mode_q,
    output logic              tick_a,
    output logic              tick_b
);

    logic [NUM_CLK-1:0] restart;
    logic [NUM_CLK-1:0] ticks;

    pwmdiv_mode_reg #(.N_HALF(NUM_CLK), .H_W(HALF_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mode_q   (mode_q),
        .restart_o(restart)
    );

    // One divider per half-word of the mode register.
    for (genvar g = 0; g < NUM_CLK; g++) begin : g_div
        half_cfg_t cfg;
        assign cfg = half_cfg_t'(mode_q[g*HALF_W +: HALF_W]);

        pwmdiv_divider #(.DIV_W(DIV_W), .PSC_W(PSC_W), .PSC_MAX(PSC_MAX)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_i    (cfg.div),
            .psc_i    (cfg.psc),
            .restart_i(restart[g]),
            .tick_o   (ticks[g])
        );
    end

    assign tick_a = ticks[0];
    assign tick_b = ticks[1];

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && !tick_a && !tick_b));

endmodule

// File: tb/tb_pwmdiv_top.sv
module tb_pwmdiv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mode_q;
    logic        tick_a, tick_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    string tag_ovr = "";

    logic [31:0] shadow = '0;
    int cnt_a = 0;
    int cnt_b = 0;

    pwmdiv_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_q(mode_q), .tick_a(tick_a), .tick_b(tick_b)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic int period_of(logic [15:0] h);
        int p;
        int d;
        p = int'(h[11:8]);
        d = int'(h[7:0]);
        if (d == 0 || p > 10) return 0;
        return (1 << p) * d;
    endfunction

    function automatic bit exp_tick(logic [15:0] h, int n);
        int per;
        per = period_of(h);
        return (per > 0) && (n > 0) && (n % per == 0);
    endfunction

    function automatic string req_of(logic [15:0] h);
        if (tag_ovr != "") return tag_ovr;
        if (h == 16'h0) return "R5";
        if (period_of(h) == 0) return "R6";
        return "R3";
    endfunction

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One master cycle: drive at negedge, model at posedge, check at negedge.
    task automatic step(bit we, logic [31:0] wd);
        wr_en = we;
        wr_data = wd;
        @(posedge clk);
        cyc++;
        if (we && wd[15:0] != shadow[15:0]) cnt_a = 0; else cnt_a++;
        if (we && wd[31:16] != shadow[31:16]) cnt_b = 0; else cnt_b++;
        if (we) shadow = wd;
        @(negedge clk);
        wr_en = 1'b0;
        check_eq(req_of(shadow[15:0]), "tick_a", 32'(tick_a), 32'(exp_tick(shadow[15:0], cnt_a)));
        check_eq(req_of(shadow[31:16]), "tick_b", 32'(tick_b), 32'(exp_tick(shadow[31:16], cnt_b)));
        check_eq("R2", "mode_q", mode_q, shadow);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, '0);
    endtask

    function automatic logic [15:0] mk(int p, int d);
        return {4'h0, 4'(p), 8'(d)};
    endfunction

    function automatic logic [15:0] rand_half(logic [15:0] cur);
        case ($urandom % 8)
            0: return 16'h0;
            1: return {4'($urandom), 4'(11 + $urandom % 5), 8'(1 + $urandom % 200)};
            2: return {4'h0, 4'($urandom % 4), 8'h00};
            3: return cur;
            default: return {4'($urandom), 4'($urandom % 4), 8'(1 + $urandom % 10)};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240607));
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state while reset is held
        check_eq("R1", "mode_q", mode_q, 32'h0);
        check_eq("R1", "tick_a", 32'(tick_a), 32'h0);
        check_eq("R1", "tick_b", 32'(tick_b), 32'h0);
        rst_n = 1'b1;
        cnt_a = 0;
        cnt_b = 0;
        tag_ovr = "R1";
        idle(5);
        tag_ovr = "";

        // R3: two different running periods
        step(1'b1, {mk(0, 5), mk(2, 3)});
        idle(40);

        // R4: period of one cycle, high every cycle
        tag_ovr = "R4";
        step(1'b1, {mk(0, 5), mk(0, 1)});
        idle(10);
        tag_ovr = "";

        // R7: change A in the middle of a period
        step(1'b1, {mk(0, 5), mk(1, 7)});
        idle(6);
        tag_ovr = "R7";
        step(1'b1, {mk(0, 5), mk(1, 3)});
        idle(20);

        // R8: identical rewrites mid-period leave the phase alone
        tag_ovr = "R8";
        for (int i = 0; i < 8; i++) begin
            step(1'b1, shadow);
            idle(2);
        end

        // R9: change only B; A keeps its phase
        tag_ovr = "R9";
        step(1'b1, {mk(2, 2), shadow[15:0]});
        idle(12);
        step(1'b1, {mk(0, 3), shadow[15:0]});
        idle(12);

        // R6: exponent above 10 and a zero divisor with nonzero half
        tag_ovr = "R6";
        step(1'b1, {mk(3, 0), mk(11, 5)});
        idle(40);
        step(1'b1, {mk(0, 2), mk(15, 1)});
        idle(20);

        // R5: zero half-words
        tag_ovr = "R5";
        step(1'b1, 32'h0);
        idle(20);

        // R10: largest exponent gives 1024*d
        tag_ovr = "R10";
        step(1'b1, {16'h0, mk(10, 1)});
        idle(2100);
        step(1'b1, {mk(10, 2), mk(10, 1)});
        idle(2100);
        tag_ovr = "";

        // Random writes at random cycles
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 40 == 0)
                step(1'b1, {rand_half(shadow[31:16]), rand_half(shadow[15:0])});
            else
                step(1'b0, $urandom);
        end

        done = 1;
        finish_run();
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            finish_run();
        end
    end
endmodule